// File: doc/BRIEF.md
# Daisy-Chainable Serial Channel Register Bank

This block is a three-wire serial slave that keeps eighteen 10-bit channel setpoints. A host lowers an active-low select, shifts a 16-bit word in most-significant-bit first on the serial clock, and raises the select again. On that rising edge the word is split into a test bit, a channel address and a setpoint, and the addressed setpoint register is written. Every setpoint is held on a wide parallel output bus for the downstream converters. Each accepted write also pulses a one-cycle strobe that carries the channel index.

The serial lines are oversampled in the block's own clock domain. They pass through a synchronizer, and the edges of the serial clock are found from the synchronized copy. The last stage of the shift register drives a serial output, and that output changes on the falling serial clock edge. Several instances can share one select and one serial clock, with each serial output wired to the next instance's serial input. The chain then acts as one long register of 16 bits per device, and every device commits on the same select release.

A small control state machine sequences the frame. `ST_IDLE` waits for the select to go low and moves to `ST_SHIFT`. `ST_SHIFT` moves serial bits in until the select rises and then moves to `ST_COMMIT`. `ST_COMMIT` decodes and writes in one cycle and always returns to `ST_IDLE`.

Top module: `chain_setpoint_regs`

## Requirements
- R1: While the select is low, the serial input is sampled on each rising serial clock edge and shifted in, so that the first bit of a 16-bit frame ends up as word bit 15 and the last bit as bit 0.
- R2: On the rising edge of the select, a frame of at least 16 bits with bit 15 = 0 writes bits 9:0 into the channel whose binary index is bits 14:10. Index 0 is the first channel and index 17 the eighteenth.
- R3: A frame whose bit 15 is 1 leaves every setpoint unchanged.
- R4: A frame whose address field (bits 14:10) is 18 to 31 leaves every setpoint unchanged.
- R5: A frame of fewer than 16 bits, including an empty one, leaves every setpoint unchanged.
- R6: A frame longer than 16 bits is decoded from the last 16 bits shifted in.
- R7: While the select is high, serial clock edges neither shift the register nor change the serial output.
- R8: The serial output is the shift register's bit 15 and is updated on the falling serial clock edge. A bit applied at the input appears on the output at the 16th falling edge after it was sampled.
- R9: In a chain of two devices, a 32-bit frame puts its first 16-bit word into the downstream device and its last word into the upstream one, and both write in the same clock cycle.
- R10: An asynchronous active-low reset clears all setpoints, the serial output and the update strobe to zero.
- R11: Each accepted write raises the update strobe for exactly one cycle with the written channel index. Rejected frames raise no strobe.
- R12: A write changes only the addressed channel. All other setpoints keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output (last shift stage) |
| setpoints | output | NUM_CH*DATA_W (180) | All setpoints, channel c at bits c*DATA_W +: DATA_W |
| upd_valid | output | 1 | One-cycle write strobe |
| upd_chan | output | ADDR_W (5) | Channel index of the write being strobed |

## Verification
The bench builds two instances with the default shape: 18 channels, 10-bit setpoints, a 5-bit address and a two-stage synchronizer. The second instance's serial input is wired to the first instance's serial output. With a 5-bit address, the bench can sweep all 32 address codes with the test bit both clear and set, which covers every legal channel and every out-of-range code. The chained pair, together with frames of 0, 15, 16, 20 and 32 bits, exercises the 16-falling-edge output delay, last-16-bits decoding and simultaneous commit. A bench-side 32-bit shift model predicts the serial output after every falling edge.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_cnt,
    input  logic              shift_en,
    input  logic              out_en,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              full,
    output logic              dout
);

    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(WORD_W);

    logic [WORD_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;
    logic              dout_q;

    // data shifts in at the LSB, so the oldest bit sits at the MSB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= {sh_q[WORD_W-2:0], din};
    end

    // saturating count of bits in the current frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (clr_cnt)                     cnt_q <= '0;
        else if (shift_en && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // last stage presented on the falling serial edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dout_q <= 1'b0;
        else if (out_en) dout_q <= sh_q[WORD_W-1];
    end

    assign word = sh_q;
    assign full = (cnt_q == CNT_MAX);
    assign dout = dout_q;

endmodule

// File: rtl/ssr_bank.sv
module ssr_bank #(
    parameter int NUM_CH = 18,
    parameter int DATA_W = 10,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] values,
    output logic                     upd_valid,
    output logic [ADDR_W-1:0]        upd_chan
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_CH - 1);

    logic              accept;
    logic [DATA_W-1:0] val_q [NUM_CH];

    assign accept = wr_en && (wr_addr <= LAST_ADDR);

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                  val_q[g] <= '0;
                else if (accept && wr_addr == ADDR_W'(g))    val_q[g] <= wr_data;
            end
            assign values[g*DATA_W +: DATA_W] = val_q[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_chan  <= '0;
        end else begin
            upd_valid <= accept;
            if (accept) upd_chan <= wr_addr;
        end
    end

endmodule

// File: rtl/chain_setpoint_regs.sv
module chain_setpoint_regs
    import ssr_pkg::*;
#(
    parameter int NUM_CH      = 18,
    parameter int DATA_W      = 10,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_sel_n,
    input  logic                     ser_din,
    output logic                     ser_dout,
    output logic [NUM_CH*DATA_W-1:0] setpoints,
    output logic                     upd_valid,
    output logic [ADDR_W-1:0]        upd_chan
);

    localparam int WORD_W  = 1 + ADDR_W + DATA_W;
    localparam int TEST_B  = WORD_W - 1;
    localparam int ADDR_HI = WORD_W - 2;

    logic sclk_s, sel_n_s, din_s;
    logic sclk_prev;
    logic sclk_rise, sclk_fall;

    ctl_state_t state_q, state_d;
    logic shifting, clr_cnt, commit;

    logic [WORD_W-1:0] word;
    logic              full;
    logic              wr_en;

    // serial lines into the block clock domain; select idles high
    ssr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_clk, ser_sel_n, ser_din}),
        .dout ({sclk_s, sel_n_s, din_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!sel_n_s) state_d = ST_SHIFT;
            ST_SHIFT:  if (sel_n_s)  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the control machine
    always_comb begin
        shifting = 1'b0;
        clr_cnt  = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE:   clr_cnt  = 1'b1;
            ST_SHIFT:  shifting = ~sel_n_s;
            ST_COMMIT: commit   = 1'b1;
            default:   clr_cnt  = 1'b1;
        endcase
    end

    ssr_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_cnt (clr_cnt),
        .shift_en(shifting & sclk_rise),
        .out_en  (shifting & sclk_fall),
        .din     (din_s),
        .word    (word),
        .full    (full),
        .dout    (ser_dout)
    );

    assign wr_en = commit & full & ~word[TEST_B];

    ssr_bank #(
        .NUM_CH(NUM_CH),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (word[ADDR_HI -: ADDR_W]),
        .wr_data  (word[DATA_W-1:0]),
        .values   (setpoints),
        .upd_valid(upd_valid),
        .upd_chan (upd_chan)
    );

endmodule

// File: rtl/chain_setpoint_regs_chk.sv
module chain_setpoint_regs_chk
    import ssr_pkg::*;
#(
    parameter int NUM_CH = 18,
    parameter int DATA_W = 10,
    parameter int ADDR_W = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sel_n_s,
    input logic                     ser_dout,
    input logic [NUM_CH*DATA_W-1:0] setpoints,
    input logic                     upd_valid,
    input logic [ADDR_W-1:0]        upd_chan,
    input ctl_state_t               state_q
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_CH - 1);

    // R4: only legal channel indices are ever strobed
    a_r4_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_chan <= LAST_ADDR));

    // R11: strobe lasts a single cycle
    a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid);

    // R7: serial output frozen while select is high
    a_r7_dout_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> $stable(ser_dout));

    // R12: setpoints move only together with a write strobe
    a_r12_change_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(setpoints) |-> upd_valid);

    // R2: a write follows a released select
    a_r2_write_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(sel_n_s, 2));

    // R2: control machine stays within its named states
    a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_IDLE, ST_SHIFT, ST_COMMIT});

endmodule

bind chain_setpoint_regs chain_setpoint_regs_chk #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n_s  (sel_n_s),
    .ser_dout (ser_dout),
    .setpoints(setpoints),
    .upd_valid(upd_valid),
    .upd_chan (upd_chan),
    .state_q  (state_q)
);

// File: tb/chain_setpoint_regs_test.sv
`timescale 1ns/1ps
module chain_setpoint_regs_test;

    localparam int NCH = 18;
    localparam int DW  = 10;
    localparam int AW  = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, sclk, sel_n, sdi;
    logic sdo, sdo2;
    logic [NCH*DW-1:0] sp, sp2;
    logic v, v2;
    logic [AW-1:0] ch, ch2;

    chain_setpoint_regs uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n), .ser_din(sdi),
        .ser_dout(sdo), .setpoints(sp), .upd_valid(v), .upd_chan(ch)
    );

    chain_setpoint_regs u_next (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n), .ser_din(sdo),
        .ser_dout(sdo2), .setpoints(sp2), .upd_valid(v2), .upd_chan(ch2)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [DW-1:0] exp1 [NCH];
    logic [DW-1:0] exp2 [NCH];
    logic [31:0]   mdl = '0;
    int stb1 = 0, stb2 = 0;
    logic [AW-1:0] last1 = '0;
    longint cyc = 0, cyc1 = -1, cyc2 = -2;

    always @(negedge clk) begin
        cyc++;
        if (rst_n === 1'b1) begin
            if (v)  begin stb1++; last1 = ch; cyc1 = cyc; end
            if (v2) begin stb2++; cyc2 = cyc; end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic pause(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bank(input string tag);
        int bad = -1;
        for (int c = 0; c < NCH; c++)
            if (sp[c*DW +: DW] !== exp1[c] && bad < 0) bad = c;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, tag, sp[bad*DW +: DW], exp1[bad]);
    endtask

    task automatic check_bank2(input string tag);
        int bad = -1;
        for (int c = 0; c < NCH; c++)
            if (sp2[c*DW +: DW] !== exp2[c] && bad < 0) bad = c;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, tag, sp2[bad*DW +: DW], exp2[bad]);
    endtask

    // returns 1 if uut accepts
    function automatic bit model_commit(input int n);
        logic [15:0] w1, w2;
        bit acc = 0;
        w1 = mdl[15:0];
        w2 = mdl[31:16];
        if (n >= 16) begin
            if (!w1[15] && w1[14:10] < 5'd18) begin exp1[w1[14:10]] = w1[9:0]; acc = 1; end
            if (!w2[15] && w2[14:10] < 5'd18) exp2[w2[14:10]] = w2[9:0];
        end
        return acc;
    endfunction

    // shifts n bits, MSB of the low n bits first; checks serial output after each fall (R8)
    task automatic send(input int n, input logic [63:0] bits, output bit acc);
        sel_n = 1'b0;
        pause(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            pause(4);
            sclk = 1'b1;
            mdl = {mdl[30:0], bits[i]};
            pause(4);
            sclk = 1'b0;
            pause(4);
            chk(sdo === mdl[15], "R8 serial output after falling edge", sdo, mdl[15]);
        end
        sel_n = 1'b1;
        acc = model_commit(n);
        pause(10);
    endtask

    function automatic logic [15:0] mk(input bit tb, input int a, input int d);
        return {tb, 5'(a), 10'(d)};
    endfunction

    initial begin
        bit acc;
        int s0;
        logic hold;
        rst_n = 1'b0; sclk = 1'b0; sel_n = 1'b1; sdi = 1'b0;
        for (int c = 0; c < NCH; c++) begin exp1[c] = '0; exp2[c] = '0; end
        pause(5);
        rst_n = 1'b1;
        pause(3);

        // R10 reset state
        chk(sp === '0, "R10 setpoints after reset", sp[31:0], 0);
        chk(sp2 === '0, "R10 downstream setpoints after reset", sp2[31:0], 0);
        chk(sdo === 1'b0, "R10 serial output after reset", sdo, 0);
        chk(v === 1'b0, "R10 strobe after reset", v, 0);

        // R1 R2 R4 R11 R12: all 32 address codes, test bit clear
        for (int a = 0; a < 32; a++) begin
            s0 = stb1;
            send(16, 64'(mk(1'b0, a, (a * 97 + 13) % 1024)), acc);
            check_bank(a < NCH ? "R2 R12 write to addressed channel" : "R4 out-of-range address ignored");
            check_bank2("R9 downstream bank follows chain");
            chk(stb1 - s0 == (acc ? 1 : 0), "R11 strobe count per frame", stb1 - s0, acc ? 1 : 0);
            if (acc) chk(last1 == 5'(a), "R11 strobe channel index", last1, a);
        end

        // R3: test bit set, all 32 codes
        for (int a = 0; a < 32; a++) begin
            s0 = stb1;
            send(16, 64'(mk(1'b1, a, 1023 - a)), acc);
            check_bank("R3 test bit set ignored");
            chk(stb1 == s0, "R3 R11 no strobe for test-bit frame", stb1 - s0, 0);
        end

        // R5: short frames
        s0 = stb1;
        send(15, 64'(mk(1'b0, 3, 10'h155) >> 1), acc);
        check_bank("R5 15-bit frame ignored");
        chk(stb1 == s0, "R5 no strobe for short frame", stb1 - s0, 0);
        send(0, 64'd0, acc);
        check_bank("R5 empty frame ignored");
        chk(stb1 == s0, "R5 no strobe for empty frame", stb1 - s0, 0);

        // R6: longer frames decode the last 16 bits
        s0 = stb1;
        send(20, {44'd0, 4'hB, mk(1'b0, 17, 10'h3FF)}, acc);
        check_bank("R6 20-bit frame last word");
        chk(sp[17*DW +: DW] === 10'h3FF, "R6 channel 17 value", sp[17*DW +: DW], 10'h3FF);
        chk(stb1 - s0 == 1, "R6 one strobe", stb1 - s0, 1);
        send(40, {24'd0, 8'hA5, mk(1'b1, 31, 0), mk(1'b0, 0, 10'h2C1)}, acc);
        check_bank("R6 40-bit frame last word");
        chk(sp[0 +: DW] === 10'h2C1, "R6 channel 0 value", sp[0 +: DW], 10'h2C1);

        // R7: clock toggles with select high
        hold = sdo;
        for (int k = 0; k < 20; k++) begin
            sdi = k[0];
            pause(4); sclk = 1'b1; pause(4); sclk = 1'b0;
        end
        pause(6);
        chk(sdo === hold, "R7 serial output unchanged while deselected", sdo, hold);
        check_bank("R7 setpoints unchanged while deselected");
        // register contents untouched: the next frame's outputs follow the model (R8 checks inside)
        send(16, 64'(mk(1'b0, 8, 10'h0F0)), acc);
        check_bank("R7 frame after ignored clocks");

        // R9: two-device chain, 32-bit frame
        send(32, {32'd0, mk(1'b0, 5, 10'h155), mk(1'b0, 9, 10'h2AA)}, acc);
        chk(sp[9*DW +: DW] === 10'h2AA, "R9 last word in upstream device", sp[9*DW +: DW], 10'h2AA);
        chk(sp2[5*DW +: DW] === 10'h155, "R9 first word in downstream device", sp2[5*DW +: DW], 10'h155);
        chk(cyc1 == cyc2, "R9 simultaneous update", cyc1, cyc2);
        check_bank("R9 upstream bank");
        check_bank2("R9 downstream bank");

        // R12: overwrite one channel, neighbours keep values
        send(16, 64'(mk(1'b0, 9, 10'h001)), acc);
        check_bank("R12 overwrite leaves others");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule